// File: doc/BRIEF.md
# GPIO Port Data Register

This block is the data side of a 16-line general-purpose I/O port. Each line has a bit in a direction register and a bit in a data latch, and a per-line select input gives that line either to ordinary I/O or to a peripheral. A line that is an output in ordinary mode drives its latch bit onto the pin. A line in peripheral mode takes its pin value and output enable from the peripheral. Software reaches both registers through a small bus with byte-masked writes and registered reads.

A data read is put together bit by bit. An output line returns its latch bit. An input line returns the synchronized pin level, whatever the function select says. Writes always reach the latch, even when the line cannot drive it out, so a value can be preloaded before a line is turned into an output.

There are two reset inputs. The power-on reset clears everything. The second reset stands for watchdog, standby and sleep events: it clears the direction register, the pin synchronizer and the read register, but the data latch keeps its contents.

Top module: `gpio_port_data`

## Requirements
- R1: While `por_n` is low, the data latch, the direction register and `bus_rdata` are all zero, and `pin_oe` is zero on every line that is not in peripheral mode.
- R2: A write (`bus_we`=1) targets the data latch when `bus_sel`=0 and the direction register when `bus_sel`=1. `bus_be[0]` enables bits 7:0 and `bus_be[1]` enables bits 15:8. Bytes whose enable is clear keep their old value.
- R3: On a line with direction 1 (output) and `func_sel` 0, `pin_out` equals the latch bit and `pin_oe` is 1. Both appear in the cycle after the clock edge that takes the write.
- R4: A read of the data latch returns, for each bit, the latch bit when the direction bit is 1, and the synchronized pin level when the direction bit is 0, whatever `func_sel` is. A pin level is seen by a read whose edge comes two or more edges after the edge that first sampled it.
- R5: On a line with `func_sel` 1, `pin_out` follows `periph_out` and `pin_oe` follows `periph_oe`, combinationally.
- R6: On a line with direction 0 and `func_sel` 0, `pin_oe` is 0. A write still updates that line's latch bit, and the new value shows once the line is made an output.
- R7: `bus_rdata` is registered. It is loaded on an edge where `bus_re`=1 and holds its value otherwise. A read with `bus_sel`=1 returns the direction register.
- R8: While `soft_rst_n` is low, the direction register, the synchronizer and `bus_rdata` are cleared. The data latch is left unchanged.
- R9: A read and a write in the same cycle return the register contents from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst_n | input | 1 | Watchdog/standby/sleep reset, active low, asynchronous |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_sel | input | 1 | Register select: 0 data latch, 1 direction |
| bus_be | input | 2 | Byte enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_re` |
| func_sel | input | 16 | Per-line peripheral-function select |
| periph_out | input | 16 | Peripheral output values |
| periph_oe | input | 16 | Peripheral output enables |
| pin_in | input | 16 | Pin levels as seen at the pad |
| pin_out | output | 16 | Values driven toward the pads |
| pin_oe | output | 16 | Pad output enables |

## Verification
The assertions assume that `func_sel`, `periph_out` and `periph_oe` are stable around each clock edge, since the routing properties sample them there. They also assume that `bus_sel` and `bus_re` do not change between an edge and the property check of the following cycle. The bench keeps to this: it changes every input only on falling edges and asserts either reset only while the bus is idle. Because `pin_in` enters through the synchronizer, random pin changes on every cycle are allowed.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int unsigned PORT_W = 16;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic {
        SEL_DATA = 1'b0,
        SEL_DIR  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_raw,
    output logic [WIDTH-1:0] pin_sync
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = pin_raw;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_data_regs.sv
module gpio_data_regs
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH = PORT_W
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sys_rst_n,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [WIDTH/BYTE_W-1:0] wr_be,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] data_q,
    output logic [WIDTH-1:0] dir_q
);
    localparam int unsigned NBYTES = WIDTH / BYTE_W;

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic [WIDTH-1:0] dir;
    } regs_t;

    logic [WIDTH-1:0] byte_mask;
    regs_t            regs_d;

    for (genvar b = 0; b < NBYTES; b++) begin : g_mask
        assign byte_mask[b*BYTE_W +: BYTE_W] = {BYTE_W{wr_be[b]}};
    end

    always_comb begin
        regs_d.data = data_q;
        regs_d.dir  = dir_q;
        if (wr_en && wr_sel == SEL_DATA)
            regs_d.data = (data_q & ~byte_mask) | (wr_data & byte_mask);
        if (wr_en && wr_sel == SEL_DIR)
            regs_d.dir = (dir_q & ~byte_mask) | (wr_data & byte_mask);
    end

    // Data latch: only the power-on reset clears it.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) data_q <= '0;
        else        data_q <= regs_d.data;
    end

    // Direction: cleared by either reset.
    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) dir_q <= '0;
        else            dir_q <= regs_d.dir;
    end

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!por_n)
        !(wr_en && wr_sel == SEL_DATA) |=> $stable(data_q));

    assert_soft_clear_R8: assert property (@(posedge clk) disable iff (!por_n)
        !sys_rst_n |-> dir_q == '0);
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] data_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] pin_sync,
    input  logic [WIDTH-1:0] func_sel,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] periph_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] data_view
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        always_comb begin
            if (func_sel[i]) begin
                pin_out[i] = periph_out[i];
                pin_oe[i]  = periph_oe[i];
            end else begin
                pin_out[i] = data_q[i];
                pin_oe[i]  = dir_q[i];
            end
            data_view[i] = dir_q[i] ? data_q[i] : pin_sync[i];
        end
    end
endmodule

// File: rtl/gpio_port_data.sv
module gpio_port_data
    import gpio_port_pkg::*;
#(
    parameter int unsigned WIDTH       = PORT_W,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             soft_rst_n,
    input  logic             bus_we,
    input  logic             bus_re,
    input  logic             bus_sel,
    input  logic [WIDTH/BYTE_W-1:0] bus_be,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] func_sel,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] periph_oe,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    logic             sys_rst_n;
    reg_sel_e         sel;
    logic [WIDTH-1:0] data_q, dir_q, pin_sync, data_view;
    logic [WIDTH-1:0] rd_d, rd_q;

    assign sys_rst_n = por_n & soft_rst_n;
    assign sel       = reg_sel_e'(bus_sel);

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(sys_rst_n), .pin_raw(pin_in), .pin_sync(pin_sync)
    );

    gpio_data_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
        .wr_en(bus_we), .wr_sel(sel), .wr_be(bus_be), .wr_data(bus_wdata),
        .data_q(data_q), .dir_q(dir_q)
    );

    gpio_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .data_q(data_q), .dir_q(dir_q), .pin_sync(pin_sync),
        .func_sel(func_sel), .periph_out(periph_out), .periph_oe(periph_oe),
        .pin_out(pin_out), .pin_oe(pin_oe), .data_view(data_view)
    );

    always_comb begin
        rd_d = rd_q;
        if (bus_re) rd_d = (sel == SEL_DIR) ? dir_q : data_view;
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) rd_q <= '0;
        else            rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;

    assert_oe_quiet_R6: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (pin_oe & ~func_sel & ~dir_q) == '0);

    assert_periph_route_R5: assert property (@(posedge clk) disable iff (!sys_rst_n)
        ((pin_oe ^ periph_oe) & func_sel) == '0);

    assert_dir_read_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (bus_re && bus_sel) |=> bus_rdata == $past(dir_q));

    assert_rd_hold_R7: assert property (@(posedge clk) disable iff (!sys_rst_n)
        !bus_re |=> $stable(bus_rdata));

    assert_latch_read_R4: assert property (@(posedge clk) disable iff (!sys_rst_n)
        (bus_re && !bus_sel) |=> ((bus_rdata ^ $past(data_q)) & $past(dir_q)) == '0);
endmodule

// File: tb/sim_gpio_port_data.sv
module sim_gpio_port_data;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        por_n, soft_rst_n, bus_we, bus_re, bus_sel;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata, bus_rdata, func_sel, periph_out, periph_oe;
    logic [15:0] pin_in, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [15:0] m_data = '0, m_dir = '0, m_rd = '0;
    logic [15:0] m_sync[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_data u0 (
        .clk(clk), .por_n(por_n), .soft_rst_n(soft_rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_sel(bus_sel), .bus_be(bus_be),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .func_sel(func_sel), .periph_out(periph_out), .periph_oe(periph_oe),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [15:0] mask;
        if (!por_n) begin
            m_data = '0; m_dir = '0; m_rd = '0; m_sync = '{16'h0, 16'h0};
        end else if (!soft_rst_n) begin
            m_dir = '0; m_rd = '0; m_sync = '{16'h0, 16'h0};
        end else begin
            if (bus_re)
                m_rd = bus_sel ? m_dir : ((m_data & m_dir) | (m_sync[1] & ~m_dir));
            mask = {{8{bus_be[1]}}, {8{bus_be[0]}}};
            if (bus_we && !bus_sel) m_data = (m_data & ~mask) | (bus_wdata & mask);
            if (bus_we && bus_sel)  m_dir  = (m_dir & ~mask) | (bus_wdata & mask);
            m_sync.push_front(pin_in);
            void'(m_sync.pop_back());
        end
    endtask

    task automatic step();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check("R3 pin_out", pin_out, (func_sel & periph_out) | (~func_sel & m_data));
        check("R5 pin_oe", pin_oe, (func_sel & periph_oe) | (~func_sel & m_dir));
        check("R7 bus_rdata", bus_rdata, m_rd);
    endtask

    task automatic bus(logic we, logic re, logic sel, logic [1:0] be, logic [15:0] wd);
        bus_we = we; bus_re = re; bus_sel = sel; bus_be = be; bus_wdata = wd;
        step();
        bus_we = 0; bus_re = 0;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) bus(0, 0, 0, 2'b00, 16'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        m_sync = '{16'h0, 16'h0};
        por_n = 0; soft_rst_n = 1; bus_we = 0; bus_re = 0; bus_sel = 0;
        bus_be = 0; bus_wdata = 0; func_sel = 0; periph_out = 0; periph_oe = 0;
        pin_in = 16'hFFFF;
        idle(3);
        check("R1 rdata at reset", bus_rdata, 16'h0);
        check("R1 pin_oe at reset", pin_oe, 16'h0);
        por_n = 1;
        idle(1);

        bus(1, 0, 1, 2'b11, 16'hFFFF);
        bus(1, 0, 0, 2'b11, 16'hA5C3);
        check("R3 pin_out driven", pin_out, 16'hA5C3);
        check("R3 pin_oe set", pin_oe, 16'hFFFF);
        bus(1, 0, 0, 2'b10, 16'h1234);
        check("R2 upper byte only", pin_out, 16'h12C3);

        bus(0, 1, 1, 2'b00, 16'h0);
        check("R7 dir read", bus_rdata, 16'hFFFF);
        idle(1);
        check("R7 rdata holds", bus_rdata, 16'hFFFF);

        bus(1, 0, 1, 2'b11, 16'h00FF);
        pin_in = 16'hBEEF;
        idle(2);
        bus(0, 1, 0, 2'b00, 16'h0);
        check("R4 mixed read", bus_rdata, 16'hBEC3);
        pin_in = 16'h0000;
        bus(0, 1, 0, 2'b00, 16'h0);
        check("R4 latency edge 1", bus_rdata, 16'hBEC3);
        bus(0, 1, 0, 2'b00, 16'h0);
        check("R4 latency edge 2", bus_rdata, 16'hBEC3);
        bus(0, 1, 0, 2'b00, 16'h0);
        check("R4 latency edge 3", bus_rdata, 16'h00C3);

        bus(1, 0, 0, 2'b10, 16'h7700);
        check("R6 input lines quiet", pin_oe, 16'h00FF);
        bus(1, 0, 1, 2'b11, 16'hFFFF);
        check("R6 preloaded value", pin_out, 16'h77C3);

        func_sel = 16'hF000; periph_out = 16'h5000; periph_oe = 16'h3000;
        idle(1);
        check("R5 periph out", pin_out, 16'h57C3);
        check("R5 periph oe", pin_oe, 16'h3FFF);
        bus(0, 1, 0, 2'b00, 16'h0);
        check("R4 output in function mode", bus_rdata, 16'h77C3);
        bus(1, 0, 1, 2'b11, 16'h0FFF);
        bus(0, 1, 0, 2'b00, 16'h0);
        check("R4 input in function mode", bus_rdata, 16'h07C3);
        func_sel = 0; periph_out = 0; periph_oe = 0;
        bus(1, 0, 1, 2'b11, 16'hFFFF);

        bus(1, 1, 0, 2'b11, 16'h0001);
        check("R9 old value on read-write", bus_rdata, 16'h77C3);
        bus(0, 1, 0, 2'b00, 16'h0);
        check("R9 new value after", bus_rdata, 16'h0001);

        soft_rst_n = 0;
        idle(2);
        check("R8 dir cleared", pin_oe, 16'h0);
        check("R8 rdata cleared", bus_rdata, 16'h0);
        soft_rst_n = 1;
        bus(1, 0, 1, 2'b11, 16'hFFFF);
        check("R8 latch kept", pin_out, 16'h0001);
        bus(0, 1, 0, 2'b00, 16'h0);
        check("R8 latch read", bus_rdata, 16'h0001);

        por_n = 0;
        idle(1);
        por_n = 1;
        bus(1, 0, 1, 2'b11, 16'hFFFF);
        check("R1 latch cleared", pin_out, 16'h0);

        for (int n = 0; n < 400; n++) begin
            pin_in = 16'($urandom); func_sel = 16'($urandom);
            periph_out = 16'($urandom); periph_oe = 16'($urandom);
            bus(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 16'($urandom));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule